// File: doc/BRIEF.md
# Byte-Slot TDM Output Serializer

This block drives two serial data pins, each carrying a frame of 32 byte-wide time slots. Slots 0 to 31 go out on pin 0 and slots 32 to 63 go out on pin 1. Each slot takes one byte from one of 24 parallel 24-bit audio channels. A configuration entry for the slot selects the channel and the byte lane: upper, middle or lower.

A channel can therefore be sent as 8, 16 or 24 bits, and its bytes can sit in any slots and in any order. The configuration lives in 32 sixteen-bit registers, each holding the entries for two adjacent slots. These registers are loaded through a simple write port.

The block runs on a fast system clock. It samples a bit clock and a frame clock that are both synchronous to the system clock. Data changes on bit-clock falling edges, most significant bit first. A per-pin 2-bit mode field enables the pin. A sticky flag reports configurations that break the channel-ordering rules or the restrictions on the last slot of each pin.

Top module: `tdm_flex_out`

## Requirements
- R1: After reset, `sdo0`, `sdo1` and `cfg_err` are 0 and every configuration register holds 0xFFFF, so a frame sent with no writes is all zeros.
- R2: The frame edge is the bit-clock falling edge at which `fclk` is sampled 1, having been sampled 0 at the previous falling edge. On the next falling edge, bit 7 of slot 0 (pin 0) and of slot 32 (pin 1) appears. Each slot lasts 8 bit clocks and is sent MSB first, and the slots run in ascending order.
- R3: A slot field is 8 bits. Bits [4:0] give the channel (0 to 23). Bits [6:5] give the byte lane: 00 selects channel bits 23:16, 01 selects bits 15:8, and 10 selects bits 7:0.
- R4: A write of `cfg_wdata` to register `cfg_addr` = a sets the field of slot 2a from bits [7:0] and the field of slot 2a+1 from bits [15:8]. Addresses 0 to 15 cover pin 0 and addresses 16 to 31 cover pin 1.
- R5: A slot whose field is 0xFF, or is otherwise invalid (bit 7 set, lane 11, or channel above 23), drives zeros.
- R6: A pin whose mode field is not binary 11 drives 0 for the whole frame. Its slots are ignored by the error check.
- R7: Channel data is captured at the frame edge. Changes to `ch_data` later in the frame do not alter that frame's output.
- R8: After the 256th bit of a frame, both pins drive 0 until the next frame edge.
- R9: At a frame edge, `cfg_err` is set if a channel c>0 is referenced by a valid slot of an enabled pin while channel c-1 is not.
- R10: At a frame edge, `cfg_err` is set if slot 31 or slot 63 (when valid on an enabled pin) selects a lane other than 00, or shares its channel with any other valid slot. In every error case the bytes are still sent exactly as configured.
- R11: Once set, `cfg_err` stays 1 until reset, even if the configuration is later corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock, sampled by `clk` |
| fclk | input | 1 | Frame clock, sampled at bit-clock falling edges |
| mode0 | input | 2 | Pin 0 format field; 11 enables slot output |
| mode1 | input | 2 | Pin 1 format field; 11 enables slot output |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 5 | Configuration register index |
| cfg_wdata | input | 16 | Two slot fields: odd slot [15:8], even slot [7:0] |
| ch_data | input | 576 | 24 channels of 24 bits; channel c at bits [24c+23:24c] |
| sdo0 | output | 1 | Serial data, slots 0 to 31 |
| sdo1 | output | 1 | Serial data, slots 32 to 63 |
| cfg_err | output | 1 | Sticky configuration error flag |

## Verification
The assertions assume that `bclk` stays at each level for at least two system clocks. They also assume that `mode0` and `mode1` do not change at the same system clock on which a bit-clock falling edge is seen. Configuration writes and mode changes are expected between frames.

The stimulus toggles `bclk` every four system clocks. It changes `fclk` only at bit-clock rising edges. It writes registers and changes modes only while both pins are idle after a frame. The only input that moves mid-frame is `ch_data`, which is changed on purpose to show that the captured snapshot holds.

// File: rtl/tdm_flex_pkg.sv
package tdm_flex_pkg;
    localparam int NUM_CH         = 24;
    localparam int CH_W           = 24;
    localparam int BYTE_W         = 8;
    localparam int LANES          = 2;
    localparam int SLOTS_PER_LANE = 32;
    localparam int NUM_SLOTS      = LANES * SLOTS_PER_LANE;
    localparam int CFG_W          = 2 * BYTE_W;
    localparam int CFG_REGS       = NUM_SLOTS / 2;
    localparam int ADDR_W         = $clog2(CFG_REGS);
    localparam int BITS_PER_LANE  = SLOTS_PER_LANE * BYTE_W;
    localparam int CNT_W          = $clog2(BITS_PER_LANE);

    localparam logic [1:0] MODE_FLEX = 2'b11;

    typedef enum logic [1:0] {
        LANE_HI  = 2'b00,
        LANE_MID = 2'b01,
        LANE_LO  = 2'b10,
        LANE_BAD = 2'b11
    } byte_lane_e;
endpackage

// File: rtl/tdm_slot_regs.sv
module tdm_slot_regs
    import tdm_flex_pkg::*;
#(
    parameter int REGS   = CFG_REGS,
    parameter int W      = CFG_W,
    parameter int AW     = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [W-1:0]      wdata,
    output logic [REGS*W-1:0] cfg_flat
);
    logic [W-1:0] regs_d [REGS];
    logic [W-1:0] regs_q [REGS];

    always_comb begin
        for (int i = 0; i < REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we) begin
            regs_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < REGS; i++) begin
            if (!rst_n) regs_q[i] <= '1;
            else        regs_q[i] <= regs_d[i];
        end
    end

    generate
        for (genvar g = 0; g < REGS; g++) begin : g_flat
            assign cfg_flat[g*W +: W] = regs_q[g];
        end
    endgenerate

    AST_WR_LAND: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs_q[$past(addr)] == $past(wdata))); // R4
endmodule

// File: rtl/tdm_cfg_check.sv
module tdm_cfg_check
    import tdm_flex_pkg::*;
#(
    parameter int SLOTS   = NUM_SLOTS,
    parameter int PER_PIN = SLOTS_PER_LANE,
    parameter int PINS    = LANES,
    parameter int CHANS   = NUM_CH,
    parameter int BW      = BYTE_W
) (
    input  logic [SLOTS*BW-1:0] cfg,
    input  logic [PINS-1:0]     pin_on,
    output logic                viol
);
    logic [SLOTS-1:0] vld;
    logic [4:0]       chan [SLOTS];
    logic [1:0]       lane [SLOTS];
    logic [CHANS-1:0] used;

    always_comb begin
        used = '0;
        for (int s = 0; s < SLOTS; s++) begin
            chan[s] = cfg[s*BW +: 5];
            lane[s] = cfg[s*BW+5 +: 2];
            vld[s]  = pin_on[s/PER_PIN] && !cfg[s*BW+7] &&
                      (lane[s] != LANE_BAD) && (int'(chan[s]) < CHANS);
            if (vld[s]) used[chan[s]] = 1'b1;
        end
    end

    always_comb begin
        viol = 1'b0;
        for (int c = 1; c < CHANS; c++) begin
            if (used[c] && !used[c-1]) viol = 1'b1;
        end
        for (int p = 0; p < PINS; p++) begin
            if (vld[p*PER_PIN + PER_PIN - 1]) begin
                if (lane[p*PER_PIN + PER_PIN - 1] != LANE_HI) viol = 1'b1;
                for (int t = 0; t < SLOTS; t++) begin
                    if (t != p*PER_PIN + PER_PIN - 1 && vld[t] &&
                        chan[t] == chan[p*PER_PIN + PER_PIN - 1]) viol = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tdm_slot_lane.sv
module tdm_slot_lane
    import tdm_flex_pkg::*;
#(
    parameter int PER_PIN = SLOTS_PER_LANE,
    parameter int CHANS   = NUM_CH,
    parameter int CW      = CH_W,
    parameter int BW      = BYTE_W,
    localparam int SW     = $clog2(PER_PIN)
) (
    input  logic [PER_PIN*BW-1:0] cfg,
    input  logic [CHANS*CW-1:0]   snap,
    input  logic [SW-1:0]         slot_idx,
    input  logic [2:0]            bit_idx,
    input  logic                  enable,
    output logic                  bit_o
);
    logic [BW-1:0] field;
    logic [BW-1:0] sel;
    logic [4:0]    chan;
    logic [1:0]    lane;
    int            ofs;

    always_comb begin
        field = cfg[int'(slot_idx)*BW +: BW];
        chan  = field[4:0];
        lane  = field[6:5];
        sel   = '0;
        ofs   = int'(chan) * CW;
        if (!field[7] && int'(chan) < CHANS) begin
            unique case (lane)
                LANE_HI:  sel = snap[ofs + 2*BW +: BW];
                LANE_MID: sel = snap[ofs + BW +: BW];
                LANE_LO:  sel = snap[ofs +: BW];
                default:  sel = '0;
            endcase
        end
        bit_o = enable & sel[3'd7 - bit_idx];
    end
endmodule

// File: rtl/tdm_flex_out.sv
module tdm_flex_out
    import tdm_flex_pkg::*;
#(
    parameter int CHANS   = NUM_CH,
    parameter int CW      = CH_W,
    parameter int PER_PIN = SLOTS_PER_LANE,
    parameter int PINS    = LANES,
    localparam int BW     = BYTE_W,
    localparam int SLOTS  = PINS * PER_PIN,
    localparam int REGS   = SLOTS / 2,
    localparam int AW     = $clog2(REGS),
    localparam int BITS   = PER_PIN * BW,
    localparam int CNTW   = $clog2(BITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bclk,
    input  logic               fclk,
    input  logic [1:0]         mode0,
    input  logic [1:0]         mode1,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [2*BW-1:0]    cfg_wdata,
    input  logic [CHANS*CW-1:0] ch_data,
    output logic               sdo0,
    output logic               sdo1,
    output logic               cfg_err
);
    typedef struct packed {
        logic                  bclk;
        logic                  fclk_last;
        logic                  active;
        logic [CNTW-1:0]       cnt;
        logic [CHANS*CW-1:0]   snap;
        logic                  sdo0;
        logic                  sdo1;
        logic                  err;
    } state_t;

    state_t st_d, st_q;

    logic [SLOTS*BW-1:0] cfg_flat;
    logic [PINS-1:0]     pin_on;
    logic [PINS-1:0]     pin_bit;
    logic                viol;
    logic                bfall;
    logic                fedge;

    assign pin_on[0] = (mode0 == MODE_FLEX);
    assign pin_on[1] = (mode1 == MODE_FLEX);

    tdm_slot_regs #(.REGS(REGS), .W(2*BW), .AW(AW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg_flat (cfg_flat)
    );

    tdm_cfg_check #(.SLOTS(SLOTS), .PER_PIN(PER_PIN), .PINS(PINS),
                    .CHANS(CHANS), .BW(BW)) i_check (
        .cfg    (cfg_flat),
        .pin_on (pin_on),
        .viol   (viol)
    );

    generate
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            tdm_slot_lane #(.PER_PIN(PER_PIN), .CHANS(CHANS), .CW(CW), .BW(BW)) i_lane (
                .cfg      (cfg_flat[p*PER_PIN*BW +: PER_PIN*BW]),
                .snap     (st_q.snap),
                .slot_idx (st_q.cnt[CNTW-1:3]),
                .bit_idx  (st_q.cnt[2:0]),
                .enable   (pin_on[p]),
                .bit_o    (pin_bit[p])
            );
        end
    endgenerate

    assign bfall = st_q.bclk & ~bclk;
    assign fedge = bfall & fclk & ~st_q.fclk_last;

    always_comb begin
        st_d      = st_q;
        st_d.bclk = bclk;
        if (bfall) begin
            st_d.fclk_last = fclk;
            st_d.sdo0      = 1'b0;
            st_d.sdo1      = 1'b0;
            if (fedge) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                st_d.snap   = ch_data;
                st_d.err    = st_q.err | viol;
            end else if (st_q.active) begin
                st_d.sdo0 = pin_bit[0];
                st_d.sdo1 = pin_bit[1];
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == {CNTW{1'b1}}) st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo0    = st_q.sdo0;
    assign sdo1    = st_q.sdo1;
    assign cfg_err = st_q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err); // R11
    AST_PIN0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bfall && mode0 != MODE_FLEX) |=> !sdo0); // R6
    AST_PIN1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bfall && mode1 != MODE_FLEX) |=> !sdo1); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bfall && !st_q.active) |=> (!sdo0 && !sdo1)); // R8
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fedge |=> $stable(st_q.snap)); // R7
endmodule

// File: tb/test_tdm_flex_out.sv
module test_tdm_flex_out;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 24;
    localparam int NBITS = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b0;
    logic         fclk = 1'b0;
    logic [1:0]   mode0 = 2'b11;
    logic [1:0]   mode1 = 2'b11;
    logic         cfg_we = 1'b0;
    logic [4:0]   cfg_addr = '0;
    logic [15:0]  cfg_wdata = '0;
    logic [575:0] ch_data = '0;
    logic         sdo0, sdo1, cfg_err;

    int n_checks = 0;
    int n_errs   = 0;
    logic [7:0] sh [64];
    logic [1:0] exp_q [$];
    string      cur_tag = "";
    bit         armed = 1'b0;
    int         bdiv = 0;
    int         bitpos = 0;

    tdm_flex_out i_tdm_flex_out (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fclk(fclk),
        .mode0(mode0), .mode1(mode1), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ch_data(ch_data),
        .sdo0(sdo0), .sdo1(sdo1), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (bdiv == 3) begin
            bclk <= ~bclk;
            bdiv <= 0;
        end else begin
            bdiv <= bdiv + 1;
        end
    end

    function automatic logic [575:0] pattern(input int seed);
        logic [575:0] d;
        for (int c = 0; c < NCH; c++) begin
            d[c*24 +: 24] = {8'(8'h5A ^ (c + seed)), 8'(8'hC3 ^ (c*3 + seed)), 8'(8'h96 + c*7 + seed)};
        end
        return d;
    endfunction

    function automatic logic model_pin(input int p, input int k, input logic [575:0] d);
        logic [7:0] f;
        logic [7:0] by;
        int s;
        if (k >= NBITS) return 1'b0;
        if ((p == 0 && mode0 != 2'b11) || (p == 1 && mode1 != 2'b11)) return 1'b0;
        s = p*32 + k/8;
        f = sh[s];
        if (f[7] || f[6:5] == 2'b11 || int'(f[4:0]) >= NCH) return 1'b0;
        by = d[int'(f[4:0])*24 + (2 - int'(f[6:5]))*8 +: 8];
        return by[7 - (k % 8)];
    endfunction

    always @(posedge bclk) begin
        if (armed) begin
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                e = exp_q.pop_front();
                n_checks++;
                if ({sdo1, sdo0} !== e) begin
                    n_errs++;
                    $display("FAIL %s bit %0d: got {sdo1,sdo0}=%b expected %b", cur_tag, bitpos, {sdo1, sdo0}, e);
                end
                bitpos++;
            end
            if (exp_q.size() == 0) armed = 1'b0;
        end
    end

    task automatic check1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic write_reg(input int a, input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        sh[2*a]   = v[7:0];
        sh[2*a+1] = v[15:8];
    endtask

    task automatic set_slot(input int s, input logic [7:0] f);
        sh[s] = f;
        write_reg(s/2, {sh[(s/2)*2+1], sh[(s/2)*2]});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < 64; s++) sh[s] = 8'hFF;
    endtask

    // push expected bits (frame + 4 idle bits), raise frame clock, let monitor compare
    task automatic run_frame(input string tag, input bit change_mid, input logic [575:0] nd);
        for (int k = 0; k < NBITS + 4; k++) begin
            exp_q.push_back({model_pin(1, k, ch_data), model_pin(0, k, ch_data)});
        end
        cur_tag = tag;
        bitpos = 0;
        @(posedge bclk); fclk = 1'b1;
        @(posedge bclk); fclk = 1'b0;
        @(negedge bclk); armed = 1'b1;
        if (change_mid) begin
            repeat (20) @(negedge bclk);
            ch_data = nd;
        end
        wait (armed == 1'b0);
        @(posedge bclk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        do_reset();
        repeat (3) @(negedge clk);
        check1("R1 sdo0 after reset", sdo0, 1'b0);
        check1("R1 sdo1 after reset", sdo1, 1'b0);
        check1("R1 cfg_err after reset", cfg_err, 1'b0);
        ch_data = pattern(0);
        run_frame("R1 default config all zero", 1'b0, '0);

        // R2 R3 R4: three channels of 8/16/24 bits spread over both pins
        set_slot(3, 8'h00);
        set_slot(11, 8'h01);
        set_slot(12, 8'h21);
        set_slot(42, 8'h02);
        set_slot(43, 8'h22);
        set_slot(44, 8'h42);
        run_frame("R2 R3 R4 spread channels", 1'b0, '0);
        check1("R9 legal config no error", cfg_err, 1'b0);

        // R6: pin 1 disabled
        mode1 = 2'b01;
        run_frame("R6 pin1 off", 1'b0, '0);
        mode1 = 2'b11;

        // R7: data changes mid-frame
        ch_data = pattern(5);
        run_frame("R7 snapshot held", 1'b0, '0);
        run_frame("R7 mid-frame change", 1'b1, pattern(9));

        // R3 R5: reordered lanes and invalid fields
        do_reset();
        set_slot(32, 8'h40);
        set_slot(0, 8'h01);
        set_slot(5, 8'h41);
        set_slot(62, 8'h22);
        set_slot(1, 8'h9F);
        set_slot(2, 8'h7F);
        set_slot(7, 8'h1A);
        run_frame("R3 R5 reorder and invalid fields", 1'b0, '0);
        check1("R5 invalid fields raise no error", cfg_err, 1'b0);

        // R9: channel 4 used while channel 3 unused
        set_slot(20, 8'h04);
        run_frame("R9 R10 gap still sent", 1'b0, '0);
        check1("R9 sequence gap sets error", cfg_err, 1'b1);
        set_slot(20, 8'hFF);
        run_frame("R11 corrected config", 1'b0, '0);
        check1("R11 error stays set", cfg_err, 1'b1);
        do_reset();
        repeat (2) @(negedge clk);
        check1("R1 reset clears error", cfg_err, 1'b0);

        // R10: slot 31 with a middle byte
        set_slot(31, 8'h20);
        run_frame("R10 slot31 middle byte sent", 1'b0, '0);
        check1("R10 slot31 lane error", cfg_err, 1'b1);
        do_reset();

        // R10: slot 63 shares channel with another slot
        set_slot(63, 8'h00);
        set_slot(10, 8'h40);
        run_frame("R10 slot63 shared channel sent", 1'b0, '0);
        check1("R10 slot63 shared channel error", cfg_err, 1'b1);
        do_reset();

        // R10: slot 63 legal 8-bit use
        set_slot(63, 8'h00);
        run_frame("R10 slot63 legal", 1'b0, '0);
        check1("R10 slot63 legal no error", cfg_err, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule